// File: doc/BRIEF.md
# CPU Power-State Controller

This block sits beside a processor core and owns one 32-bit power control register in the core's special-purpose register space. Software writes the register to ask for a low-power mode; the block then drives three clock-enable outputs: one for the core itself, one shared by the tick timer and the interrupt controller, and one for every other unit. It also decides when the core is woken again. The low byte of the register holds the live fields. The upper bits are not stored and read as zero. The block also reports a presence flag so the unit-present register can advertise that power management exists.

Four states are used. In RUN every clock runs. In DOZE the core and the general units stop, while the timer and interrupt controller keep ticking. In SLEEP every clock stops. SUSPEND stops every clock and can be left only by reset. The transitions are as follows. ENTER goes from RUN to a mode on a register write that requests one. WAKE goes from DOZE or SLEEP to RUN on a pending interrupt, a timer event or exception entry. REMODE goes from DOZE or SLEEP to a new mode, or to RUN, on a register write. LOCK goes from any non-suspended state to SUSPEND on a write with the suspend bit set. Exception entry also clears the doze and sleep request bits. This keeps a woken core from falling straight back into a halt.

Field layout of the register: bits 3:0 are the slow-down factor, bit 4 requests doze, bit 5 requests sleep, bit 6 enables dynamic clock gating and bit 7 requests suspend. The slow-down factor and the dynamic-gating flag are passed out to the clock logic and have no effect on the state machine.

Top module: `pwr_mgmt_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, all three clock enables are 1, and slow_div and dyn_gate_en are 0.
- R2: A write (spr_sel=1, spr_we=1) outside SUSPEND stores spr_wdata[7:0]. spr_rdata returns the stored byte in bits 7:0 with bits 31:8 zero while spr_sel=1, and returns 0 while spr_sel=0.
- R3: slow_div equals register bits 3:0 and dyn_gate_en equals register bit 6, and neither field changes the clock enables.
- R4: A write with bit 4 set and bits 5 and 7 clear gives core_clk_en=0, unit_clk_en=0 and tick_pic_clk_en=1 from the cycle after the write (DOZE).
- R5: A write with bit 5 set and bit 7 clear gives all three enables 0 from the cycle after the write (SLEEP).
- R6: A write with bit 7 set gives all three enables 0 from the cycle after the write (SUSPEND).
- R7: Precedence when several request bits are set: bit 7 (suspend) over bit 5 (sleep) over bit 4 (doze).
- R8: In DOZE or SLEEP, irq_pending=1 for one cycle restores all three enables on the next edge, and the register keeps its value.
- R9: In DOZE or SLEEP, timer_event=1 for one cycle restores all three enables on the next edge.
- R10: exc_entry=1 outside SUSPEND clears register bits 5:4 and keeps the other bits. In DOZE or SLEEP it also wakes the core. A write in the same cycle is stored with bits 5:4 cleared.
- R11: In SUSPEND, irq_pending, timer_event, exc_entry and writes have no effect: the enables stay 0 and the register is unchanged until reset.
- R12: pm_present is 1 at all times.
- R13: A write with bits 4, 5 and 7 all clear leaves all three enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_sel | input | 1 | Power control register selected by the core |
| spr_we | input | 1 | Write strobe, qualified by spr_sel |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data, zero when not selected |
| irq_pending | input | 1 | An enabled interrupt is pending |
| exc_entry | input | 1 | The core enters an exception or interrupt this cycle |
| timer_event | input | 1 | Tick timer event pulse |
| core_clk_en | output | 1 | Clock enable for the core |
| tick_pic_clk_en | output | 1 | Clock enable for tick timer and interrupt controller |
| unit_clk_en | output | 1 | Clock enable for all other units |
| slow_div | output | 4 | Slow-down factor field |
| dyn_gate_en | output | 1 | Dynamic clock gating enable field |
| pm_present | output | 1 | Power-management presence flag |

## Verification
The assertions assume that rst_n is held low across the first clock edge and that spr_we is only meaningful together with spr_sel. They also assume the wake inputs are single-cycle, level-sampled signals with no ordering against writes. The wake property excludes the cycle in which a write arrives, because a write decides the next mode. The bench keeps to these assumptions. It drives every input at the falling edge, pulses wake sources for exactly one cycle, and resets at the start of each step of the 256-value write sweep, so that each step begins in RUN.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Live field layout of the power control register (low byte)
    localparam int FIELD_W   = 8;
    localparam int SLOW_LSB  = 0;
    localparam int SLOW_W    = 4;
    localparam int DOZE_BIT  = 4;
    localparam int SLEEP_BIT = 5;
    localparam int DYN_BIT   = 6;
    localparam int SUSP_BIT  = 7;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DOZE    = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_SUSPEND = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic core;
        logic tick_pic;
        logic units;
    } gate_t;

    // Mode requested by a field value; suspend > sleep > doze
    function automatic pm_state_e decode_mode(input logic [FIELD_W-1:0] f);
        pm_state_e m;
        if (f[SUSP_BIT])       m = ST_SUSPEND;
        else if (f[SLEEP_BIT]) m = ST_SLEEP;
        else if (f[DOZE_BIT])  m = ST_DOZE;
        else                   m = ST_RUN;
        return m;
    endfunction

endpackage

// File: rtl/pmc_reg.sv
module pmc_reg
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_fire,
    input  logic [FIELD_W-1:0] wr_byte,
    input  logic               exc_entry,
    input  logic               hold,
    output logic [FIELD_W-1:0] field_d,
    output logic [FIELD_W-1:0] field_q
);

    always_comb begin
        field_d = field_q;
        if (!hold) begin
            if (wr_fire) begin
                field_d = wr_byte;
            end
            // exception entry wins over a same-cycle write for the request bits
            if (exc_entry) begin
                field_d[DOZE_BIT]  = 1'b0;
                field_d[SLEEP_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= '0;
        end else begin
            field_q <= field_d;
        end
    end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_fire,
    input  logic [FIELD_W-1:0] field_d,
    input  logic               wake,
    output pm_state_e          state_q
);

    pm_state_e state_d;
    pm_state_e req_mode;

    assign req_mode = decode_mode(field_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_fire) state_d = req_mode;          // ENTER or LOCK
            end
            ST_DOZE, ST_SLEEP: begin
                if (wr_fire)   state_d = req_mode;        // REMODE or LOCK
                else if (wake) state_d = ST_RUN;          // WAKE
            end
            ST_SUSPEND: begin
                state_d = ST_SUSPEND;                     // left only by reset
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
    import pmc_pkg::*;
(
    input  pm_state_e state_q,
    output gate_t     gates
);

    always_comb begin
        unique case (state_q)
            ST_RUN:     gates = '{core: 1'b1, tick_pic: 1'b1, units: 1'b1};
            ST_DOZE:    gates = '{core: 1'b0, tick_pic: 1'b1, units: 1'b0};
            ST_SLEEP:   gates = '{core: 1'b0, tick_pic: 1'b0, units: 1'b0};
            ST_SUSPEND: gates = '{core: 1'b0, tick_pic: 1'b0, units: 1'b0};
        endcase
    end

endmodule

// File: rtl/pwr_mgmt_ctrl.sv
module pwr_mgmt_ctrl
    import pmc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spr_sel,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    input  logic              irq_pending,
    input  logic              exc_entry,
    input  logic              timer_event,
    output logic              core_clk_en,
    output logic              tick_pic_clk_en,
    output logic              unit_clk_en,
    output logic [SLOW_W-1:0] slow_div,
    output logic              dyn_gate_en,
    output logic              pm_present
);

    localparam int PAD_W = DATA_W - FIELD_W;

    pm_state_e          state_q;
    logic [FIELD_W-1:0] field_q;
    logic [FIELD_W-1:0] field_d;
    logic               hold;
    logic               wr_fire;
    logic               wake;
    gate_t              gates;

    assign hold    = (state_q == ST_SUSPEND);
    assign wr_fire = spr_sel && spr_we && !hold;
    assign wake    = irq_pending || timer_event || exc_entry;

    pmc_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .wr_byte   (spr_wdata[FIELD_W-1:0]),
        .exc_entry (exc_entry),
        .hold      (hold),
        .field_d   (field_d),
        .field_q   (field_q)
    );

    pmc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .field_d (field_d),
        .wake    (wake),
        .state_q (state_q)
    );

    pmc_gate u_gate (
        .state_q (state_q),
        .gates   (gates)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign spr_rdata = spr_sel ? {{PAD_W{1'b0}}, field_q} : '0;
        end else begin : g_nopad
            assign spr_rdata = spr_sel ? field_q[DATA_W-1:0] : '0;
        end
    endgenerate

    assign core_clk_en     = gates.core;
    assign tick_pic_clk_en = gates.tick_pic;
    assign unit_clk_en     = gates.units;
    assign slow_div        = field_q[SLOW_LSB +: SLOW_W];
    assign dyn_gate_en     = field_q[DYN_BIT];
    assign pm_present      = 1'b1;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spr_sel,
    input logic               spr_we,
    input logic [DATA_W-1:0]  spr_wdata,
    input logic               irq_pending,
    input logic               exc_entry,
    input logic               core_clk_en,
    input logic               tick_pic_clk_en,
    input logic [FIELD_W-1:0] field_q,
    input pm_state_e          state_q
);

    logic wr;
    assign wr = spr_sel && spr_we;

    // R4: the core never runs while the timer and interrupt clock is stopped
    assert_core_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> tick_pic_clk_en);

    assert_doze_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q != ST_SUSPEND && !exc_entry && spr_wdata[DOZE_BIT]
         && !spr_wdata[SLEEP_BIT] && !spr_wdata[SUSP_BIT])
        |=> (!core_clk_en && tick_pic_clk_en));

    assert_sleep_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q != ST_SUSPEND && !exc_entry && spr_wdata[SLEEP_BIT]
         && !spr_wdata[SUSP_BIT])
        |=> (!core_clk_en && !tick_pic_clk_en));

    assert_suspend_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && state_q != ST_SUSPEND && spr_wdata[SUSP_BIT])
        |=> (state_q == ST_SUSPEND && !tick_pic_clk_en));

    assert_irq_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DOZE || state_q == ST_SLEEP) && irq_pending && !wr)
        |=> core_clk_en);

    assert_exc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && state_q != ST_SUSPEND)
        |=> (!field_q[DOZE_BIT] && !field_q[SLEEP_BIT]));

    assert_suspend_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSPEND) |=> (state_q == ST_SUSPEND && $stable(field_q)));

endmodule

bind pwr_mgmt_ctrl pmc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .spr_sel         (spr_sel),
    .spr_we          (spr_we),
    .spr_wdata       (spr_wdata),
    .irq_pending     (irq_pending),
    .exc_entry       (exc_entry),
    .core_clk_en     (core_clk_en),
    .tick_pic_clk_en (tick_pic_clk_en),
    .field_q         (field_q),
    .state_q         (state_q)
);

// File: tb/pwr_mgmt_ctrl_tb.sv
module pwr_mgmt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spr_sel, spr_we;
    logic [31:0] spr_wdata, spr_rdata;
    logic        irq_pending, exc_entry, timer_event;
    logic        core_clk_en, tick_pic_clk_en, unit_clk_en;
    logic [3:0]  slow_div;
    logic        dyn_gate_en, pm_present;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_mgmt_ctrl #(.DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .spr_sel(spr_sel), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .irq_pending(irq_pending),
        .exc_entry(exc_entry), .timer_event(timer_event), .core_clk_en(core_clk_en),
        .tick_pic_clk_en(tick_pic_clk_en), .unit_clk_en(unit_clk_en),
        .slow_div(slow_div), .dyn_gate_en(dyn_gate_en), .pm_present(pm_present)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // mode from bits: 3 suspend, 2 sleep, 1 doze, 0 run
    function automatic int exp_mode(input logic [7:0] v);
        if (v[7]) return 3;
        if (v[5]) return 2;
        if (v[4]) return 1;
        return 0;
    endfunction

    // {core, tick_pic, unit}
    function automatic logic [2:0] exp_gates(input int m);
        if (m == 0) return 3'b111;
        if (m == 1) return 3'b010;
        return 3'b000;
    endfunction

    task automatic gates_chk(input string req, input logic [2:0] exp);
        chk(req, {29'd0, core_clk_en, tick_pic_clk_en, unit_clk_en}, {29'd0, exp});
    endtask

    task automatic read_chk(input string req, input logic [31:0] exp);
        spr_sel = 1'b1; spr_we = 1'b0;
        #1;
        chk(req, spr_rdata, exp);
        spr_sel = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] v, input logic exc);
        @(negedge clk);
        spr_sel = 1'b1; spr_we = 1'b1; spr_wdata = v; exc_entry = exc;
        @(negedge clk);
        spr_sel = 1'b0; spr_we = 1'b0; exc_entry = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_pending = 1'b1;
        @(negedge clk); irq_pending = 1'b0;
    endtask

    task automatic pulse_timer();
        @(negedge clk); timer_event = 1'b1;
        @(negedge clk); timer_event = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); exc_entry = 1'b1;
        @(negedge clk); exc_entry = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; spr_sel = 1'b0; spr_we = 1'b0; spr_wdata = '0;
        irq_pending = 1'b0; exc_entry = 1'b0; timer_event = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        gates_chk("R1 gates after reset", 3'b111);
        read_chk("R1 register after reset", 32'h0);
        chk("R1 slow_div after reset", {28'd0, slow_div}, 32'h0);
        chk("R1 dyn_gate_en after reset", {31'd0, dyn_gate_en}, 32'h0);
        chk("R12 presence flag", {31'd0, pm_present}, 32'h1);

        // R2: deselected read returns zero
        do_write(32'h0000_0043, 1'b0);
        #1;
        chk("R2 rdata with spr_sel low", spr_rdata, 32'h0);

        // Sweep every low-byte value; upper bits carry junk that must read back as zero
        for (int v = 0; v < 256; v++) begin
            int m;
            m = exp_mode(v[7:0]);
            do_reset();
            do_write(32'hA5C3_0000 | v, 1'b0);
            // R4 doze, R5 sleep, R6 suspend, R13 no mode, R7 precedence
            gates_chk("R7 gates after write (R4/R5/R6/R13)", exp_gates(m));
            read_chk("R2 readback", {24'd0, v[7:0]});
            chk("R3 slow_div field", {28'd0, slow_div}, {28'd0, v[3:0]});
            chk("R3 dyn_gate_en field", {31'd0, dyn_gate_en}, {31'd0, v[6]});
            if (m == 1 || m == 2) begin
                if (v[0]) begin
                    pulse_irq();
                    gates_chk("R8 irq wake", 3'b111);
                    read_chk("R8 register kept on wake", {24'd0, v[7:0]});
                end else begin
                    pulse_timer();
                    gates_chk("R9 timer wake", 3'b111);
                end
            end else if (m == 3) begin
                pulse_irq();
                pulse_timer();
                pulse_exc();
                do_write(32'h0000_0000, 1'b0);
                gates_chk("R11 suspend ignores wake and write", 3'b000);
                read_chk("R11 register frozen in suspend", {24'd0, v[7:0]});
            end
        end

        // R10: exception entry wakes from sleep and clears only bits 5:4
        do_reset();
        do_write(32'h0000_007F, 1'b0);
        gates_chk("R5 sleep entered", 3'b000);
        pulse_exc();
        gates_chk("R10 exception wakes", 3'b111);
        read_chk("R10 request bits cleared", 32'h0000_004F);

        // R10: same-cycle write and exception, exception clears request bits
        do_write(32'h0000_003A, 1'b1);
        gates_chk("R10 write with exception stays running", 3'b111);
        read_chk("R10 write with exception stored", 32'h0000_000A);

        // R10: same-cycle write and exception cannot block suspend
        do_write(32'h0000_00B0, 1'b1);
        gates_chk("R10 suspend with exception still locks", 3'b000);
        read_chk("R10 suspend value stored", 32'h0000_0080);

        // R4 then R5 via rewrite in doze is not possible from a halted core; check R8 in doze with held irq
        do_reset();
        do_write(32'h0000_0010, 1'b0);
        gates_chk("R4 doze", 3'b010);
        pulse_irq();
        gates_chk("R8 wake from doze", 3'b111);
        chk("R12 presence flag at end", {31'd0, pm_present}, 32'h1);

        finish_run();
    end

endmodule